// File: doc/BRIEF.md
# CAM Chain Control Register Bank

This block sits between a host processor's simple register bus and an external chain of content-addressable memories. It owns the chain's active-low reset line, which follows a software-owned release bit. A hardware reset pulls that line low, and the line stays low after the hardware reset ends. The chain starts working only when software writes a 1 to the release bit.

The block also holds a small target register with two enables. One gates the chain's active-low full flag onto an interrupt output. The other lets an asynchronous increment input advance a time stamp. Software reads two 16-bit time stamp counters, current and purge, but cannot write them. Each counter advances by one when software writes any value to that counter's own strobe address.

Top module: `cam_chain_ctl`

## Requirements
- R1: Bit 0 of the configuration register at address 0x0 resets to 0, reads back at address 0x0, and drives `chain_rst_n` directly (0 gives low, 1 gives high).
- R2: While `rst_n` is low, `chain_rst_n` is low. After `rst_n` rises, `chain_rst_n` stays low until software writes a 1 to bit 0 of address 0x0. A write with bit 0 clear keeps the line low.
- R3: The target register at address 0x1 holds the increment-input enable in bit 0 and the full-interrupt enable in bit 1. It reads back at the same address.
- R4: `irq` is high exactly while the full-interrupt enable is 1 and `chain_full_n` is low. It follows both without a clock delay.
- R5: Any write to address 0x4, whatever the data, adds one to the current time stamp. The new value is readable at address 0x2 after the next rising clock edge.
- R6: Any write to address 0x5, whatever the data, adds one to the purge time stamp, which is read at address 0x3.
- R7: Writes to addresses 0x2 and 0x3 do not change either time stamp.
- R8: `incr_in` passes through a two-flop synchroniser. When the increment enable is 1, each rising edge advances the current time stamp by one, on the third clock edge after the input is sampled high. A level held high advances it only once. When the enable is 0, the input is ignored.
- R9: If a strobe write to 0x4 and an increment-input edge fall in the same cycle, the current time stamp advances by exactly one.
- R10: Both time stamps are 16 bits wide and wrap from 0xFFFF to 0x0000.
- R11: Hardware reset clears both time stamps and both target enables to zero.
- R12: Reads of addresses 0x4, 0x5 and any unmapped address return zero. Reads are combinational from `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| chain_full_n | input | 1 | Full flag from the memory chain, active low |
| incr_in | input | 1 | Asynchronous time stamp increment request |
| irq | output | 1 | Full interrupt, active high |
| chain_rst_n | output | 1 | Reset to the memory chain, active low |

## Verification
The hardest case to reach is a collision: a strobe write and a synchronised increment edge must advance the current counter in the same cycle. The stimulus raises `incr_in` one phase after an edge. It then places the write to 0x4 exactly two clock edges later, so that the write lands on the edge where the synchronised pulse is consumed. The reference model tracks the input's edge samples in a short queue and reproduces that alignment on every clock. The other case that takes care to reach is the wrap from 0xFFFF to 0x0000. It needs 65,536 back-to-back strobe writes, with a readback just before and just after the wrap.

// File: rtl/cam_chain_pkg.sv
package cam_chain_pkg;

  // Register addresses; strobe addresses carry no storage
  localparam int unsigned REG_CFG     = 0;
  localparam int unsigned REG_TGT     = 1;
  localparam int unsigned REG_TS_CUR  = 2;
  localparam int unsigned REG_TS_PUR  = 3;
  localparam int unsigned REG_STB_CUR = 4;
  localparam int unsigned REG_STB_PUR = 5;

  // Target register: bit 1 full-interrupt enable, bit 0 increment-input enable
  typedef struct packed {
    logic full_irq_en;
    logic incr_en;
  } tgt_t;

  localparam int TGT_W = $bits(tgt_t);

endpackage

// File: rtl/cam_incr_sync.sv
module cam_incr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

  // R8: an edge event never lasts longer than one cycle
  a_r8_single_cycle_event: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/cam_ts_counter.sv
module cam_ts_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  function automatic logic [W-1:0] step(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= step(count);
  end

  // R7: without an increment the value is frozen
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));

  // R10: the all-ones value rolls over to zero
  a_r10_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && count == '1) |=> count == '0);

endmodule

// File: rtl/cam_chain_regs.sv
module cam_chain_regs
  import cam_chain_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [TGT_W-1:0]  wdata,
  output logic              release_q,
  output tgt_t              tgt_q,
  output logic              stb_cur,
  output logic              stb_pur
);

  logic wr_cfg, wr_tgt;

  assign wr_cfg  = we && (addr == ADDR_W'(REG_CFG));
  assign wr_tgt  = we && (addr == ADDR_W'(REG_TGT));
  assign stb_cur = we && (addr == ADDR_W'(REG_STB_CUR));
  assign stb_pur = we && (addr == ADDR_W'(REG_STB_PUR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      release_q <= 1'b0;
      tgt_q     <= '0;
    end else begin
      if (wr_cfg) release_q <= wdata[0];
      if (wr_tgt) tgt_q     <= tgt_t'(wdata);
    end
  end

  // R1: a configuration write lands on the next edge
  a_r1_cfg_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> release_q == $past(wdata[0]));

  // R2: the release bit only moves on a configuration write
  a_r2_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> $stable(release_q));

  // R3: target write lands on the next edge
  a_r3_tgt_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tgt |=> tgt_q == $past(wdata));

endmodule

// File: rtl/cam_chain_ctl.sv
module cam_chain_ctl
  import cam_chain_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 16,
  parameter int TS_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              chain_full_n,
  input  logic              incr_in,
  output logic              irq,
  output logic              chain_rst_n
);

  logic            release_q;
  tgt_t            tgt_q;
  logic            stb_cur, stb_pur;
  logic            incr_rise;
  logic            cur_inc;
  logic [TS_W-1:0] ts_cur, ts_pur;
  logic            unused_wdata;

  assign unused_wdata = ^bus_wdata;

  cam_chain_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (bus_addr),
    .we        (bus_we),
    .wdata     (bus_wdata[TGT_W-1:0]),
    .release_q (release_q),
    .tgt_q     (tgt_q),
    .stb_cur   (stb_cur),
    .stb_pur   (stb_pur)
  );

  cam_incr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (incr_in),
    .rise     (incr_rise)
  );

  // Strobe and input edge merge into one increment
  assign cur_inc = stb_cur | (incr_rise & tgt_q.incr_en);

  cam_ts_counter #(.W(TS_W)) u_ts_cur (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (cur_inc),
    .count (ts_cur)
  );

  cam_ts_counter #(.W(TS_W)) u_ts_pur (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (stb_pur),
    .count (ts_pur)
  );

  assign chain_rst_n = release_q;
  assign irq         = tgt_q.full_irq_en & ~chain_full_n;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(REG_CFG):    bus_rdata[0]       = release_q;
      ADDR_W'(REG_TGT):    bus_rdata[TGT_W-1:0] = tgt_q;
      ADDR_W'(REG_TS_CUR): bus_rdata = DATA_W'(ts_cur);
      ADDR_W'(REG_TS_PUR): bus_rdata = DATA_W'(ts_pur);
      default:             bus_rdata = '0;
    endcase
  end

  // R4: an interrupt implies the chain reports full
  a_r4_irq_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !chain_full_n);

  // R9: coincident strobe and input edge count once
  a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_cur && incr_rise && tgt_q.incr_en) |=> ts_cur == $past(ts_cur) + TS_W'(1));

  // R6: purge counter moves exactly on its strobe
  a_r6_purge_step: assert property (@(posedge clk) disable iff (!rst_n)
    stb_pur |=> ts_pur == $past(ts_pur) + TS_W'(1));

endmodule

// File: tb/cam_chain_ctl_tb_top.sv
`timescale 1ns/100ps
module cam_chain_ctl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        chain_full_n = 1'b1;
  logic        incr_in = 1'b0;
  logic        irq;
  logic        chain_rst_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cam_chain_ctl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .chain_full_n (chain_full_n),
    .incr_in      (incr_in),
    .irq          (irq),
    .chain_rst_n  (chain_rst_n)
  );

  // Behavioural reference model
  bit          m_rel, m_incr_en, m_irq_en;
  int unsigned m_cur, m_pur;
  bit          samp_q[$] = '{0, 0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_incr_en = 0; m_irq_en = 0;
      m_cur = 0; m_pur = 0;
      samp_q = '{0, 0, 0};
    end else begin
      bit edge_seen;
      bit bump;
      edge_seen = samp_q[1] && !samp_q[2];
      bump = (bus_we && bus_addr == 3'd4) || (edge_seen && m_incr_en);
      if (bump) m_cur = (m_cur + 1) % 65536;
      if (bus_we && bus_addr == 3'd5) m_pur = (m_pur + 1) % 65536;
      if (bus_we && bus_addr == 3'd0) m_rel = bus_wdata[0];
      if (bus_we && bus_addr == 3'd1) begin
        m_incr_en = bus_wdata[0];
        m_irq_en  = bus_wdata[1];
      end
      samp_q.push_front(incr_in);
      samp_q.delete(3);
    end
  end

  function automatic int model_rd(input int a);
    case (a)
      0: return int'(m_rel);
      1: return int'({m_irq_en, m_incr_en});
      2: return int'(m_cur);
      3: return int'(m_pur);
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(input int a);
    case (a)
      0: return "R1";
      1: return "R3";
      2: return "R5";
      3: return "R6";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      check(rd_tag(int'(bus_addr)), int'(bus_rdata), model_rd(int'(bus_addr)));
      check("R1", int'(chain_rst_n), int'(m_rel));
      check("R4", int'(irq), int'(m_irq_en && !chain_full_n));
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
    tick();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #750000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int v;
    repeat (4) tick();
    check("R2", int'(chain_rst_n), 0);
    rst_n = 1'b1;
    repeat (3) tick();
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), v); check("R11", v, 0);
    end
    check("R2", int'(chain_rst_n), 0);
    wr(3'd0, 16'hFFFE);
    tick(); check("R2", int'(chain_rst_n), 0);
    wr(3'd0, 16'h0001);
    check("R1", int'(chain_rst_n), 1);
    rd(3'd0, v); check("R1", v, 1);

    // Full interrupt gating
    wr(3'd1, 16'h0002);
    chain_full_n = 1'b0; tick(); check("R4", int'(irq), 1);
    chain_full_n = 1'b1; tick(); check("R4", int'(irq), 0);
    wr(3'd1, 16'h0000);
    chain_full_n = 1'b0; tick(); check("R4", int'(irq), 0);
    chain_full_n = 1'b1;
    wr(3'd1, 16'hFFFF);
    rd(3'd1, v); check("R3", v, 3);
    wr(3'd1, 16'h0000);

    // Strobe writes
    for (int i = 0; i < 3; i++) wr(3'd4, 16'(i * 16'h1234));
    rd(3'd2, v); check("R5", v, 3);
    wr(3'd5, 16'hBEEF);
    rd(3'd3, v); check("R6", v, 1);
    wr(3'd2, 16'h7777);
    wr(3'd3, 16'h5555);
    rd(3'd2, v); check("R7", v, 3);
    rd(3'd3, v); check("R7", v, 1);
    rd(3'd4, v); check("R12", v, 0);
    rd(3'd5, v); check("R12", v, 0);
    rd(3'd6, v); check("R12", v, 0);

    // Increment input disabled, then enabled
    incr_in = 1'b1; repeat (4) tick();
    incr_in = 1'b0; repeat (4) tick();
    rd(3'd2, v); check("R8", v, 3);
    wr(3'd1, 16'h0001);
    incr_in = 1'b1; repeat (4) tick();
    rd(3'd2, v); check("R8", v, 4);
    repeat (5) tick();
    rd(3'd2, v); check("R8", v, 4);
    incr_in = 1'b0; repeat (4) tick();

    // Collision of strobe and input edge
    incr_in = 1'b1;
    tick();
    tick();
    bus_addr = 3'd4; bus_we = 1'b1;
    tick();
    bus_we = 1'b0;
    repeat (3) tick();
    rd(3'd2, v); check("R9", v, 5);
    incr_in = 1'b0; repeat (4) tick();

    // Reset in mid-operation
    rst_n = 1'b0;
    tick();
    check("R2", int'(chain_rst_n), 0);
    rd(3'd2, v); check("R11", v, 0);
    rst_n = 1'b1;
    repeat (2) tick();
    rd(3'd1, v); check("R11", v, 0);
    check("R2", int'(chain_rst_n), 0);

    // Wrap of the purge counter
    bus_addr = 3'd5; bus_we = 1'b1;
    repeat (65535) tick();
    bus_we = 1'b0;
    rd(3'd3, v); check("R10", v, 16'hFFFF);
    wr(3'd5, 16'h0000);
    rd(3'd3, v); check("R10", v, 0);

    finish_run();
  end

endmodule